// File: doc/BRIEF.md
# UART Receive Queue with Idle Timeout

This block holds received UART characters in a small byte queue until software reads them. Characters come from a deframer as single-cycle strobes. A detected line break arrives on its own strobe and is stored as a zero byte. Reads pop the oldest byte. The current fill level is exported so that a neighbouring block can compare it against a trigger level.

A small control register gates the queue. Its bit 2 enables reception and its bit 3 disables it. Writing bit 0 empties the queue, and that bit never reads back as set. Overflow and idle timeout are each reported as one-cycle pulses.

The idle timer restarts on every character the queue stores. It expires after four character times. A character time is the frame length in bits, taken from the line-format inputs, multiplied by a bit period given in clock cycles.

Top module: `uart_rxq`

## Requirements
- R1: The queue stores up to 16 bytes and returns them in arrival order. `count_o` gives the number held, and `pop_data_o` shows the oldest byte whenever the queue is enabled and not empty.
- R2: The queue is enabled only while control bit 2 is 1 and control bit 3 is 0. When it is not enabled, pushes, breaks and pops leave `count_o` unchanged and `pop_data_o` reads 0.
- R3: A push that arrives while 16 bytes are held, with no pop in the same cycle, is discarded. `overflow_o` is then high for exactly one cycle, the cycle after the push is captured.
- R4: A pop while the queue is empty returns 0 on `pop_data_o` and leaves `count_o` at 0.
- R5: A control write with bit 0 set empties the queue. Bits 3 and 2 are stored from the same write. `ctrl_o` returns {bit3, bit2, 0, 0}, so bit 0 always reads back as 0.
- R6: Every stored character reloads the idle timer with T = 4 × frame_bits × `bit_cycles_i` cycles. If no character is stored in the meantime, `timeout_o` pulses for one cycle exactly T clock edges after the capture edge. A bit period of 0 disables the timer.
- R7: frame_bits is 1 + data + parity + stop. Data is 6 when mode[2:1]=3, 7 when mode[2:1]=2, and 8 otherwise. Parity adds 1 when mode[5:3] is 0 or 1, and 0 otherwise. Stop is 1 when mode[7:6]=3, and 2 otherwise.
- R8: A `break_i` strobe stores the byte 0x00 when the queue is enabled, and it also restarts the idle timer.
- R9: A push and a pop in the same cycle on a full queue both take effect. `count_o` stays 16, no overflow is flagged, and the new byte becomes the newest entry.
- R10: After reset the queue is empty, `ctrl_o` reads 4'b1000 (disabled), and both pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Control write strobe |
| ctrl_wdata_i | input | 4 | Control write data: bit 0 flush, bit 2 enable, bit 3 disable |
| ctrl_o | output | 4 | Control readback |
| mode_i | input | 8 | Line format: [2:1] data bits, [5:3] parity, [7:6] stop bits |
| bit_cycles_i | input | 16 | Bit period in clock cycles |
| push_i | input | 1 | Received character strobe |
| push_data_i | input | 8 | Received character |
| break_i | input | 1 | Break detected strobe (stores 0x00) |
| pop_i | input | 1 | Read strobe |
| pop_data_o | output | 8 | Oldest byte, or 0 when empty or disabled |
| count_o | output | 5 | Bytes held |
| overflow_o | output | 1 | One-cycle overflow pulse |
| timeout_o | output | 1 | One-cycle idle timeout pulse |

## Verification
Each result has a known due time:

- **Read data:** `pop_data_o` is combinational from stored state, so it is checked in the same cycle the pop is driven, before the capture edge.
- **Level, overflow and control readback:** `count_o`, `overflow_o` and `ctrl_o` are registered. They are checked at the falling edge that follows the capture edge.
- **Timeout:** `timeout_o` is counted in falling edges after the capture edge of the last stored character. The bench requires the first high sample at exactly T and none before.

All stimulus is applied on falling edges, so every sample falls half a period away from the edge that updates the design.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned FRAME_W = 4;

  // bits per character for a given line format
  function automatic logic [FRAME_W-1:0] frame_bits(input logic [7:0] mode);
    logic [FRAME_W-1:0] n;
    n = 4'd1;
    case (mode[2:1])
      2'd3:    n = n + 4'd6;
      2'd2:    n = n + 4'd7;
      default: n = n + 4'd8;
    endcase
    if (mode[5:3] == 3'd0 || mode[5:3] == 3'd1) n = n + 4'd1;
    n = n + ((mode[7:6] == 2'd3) ? 4'd1 : 4'd2);
    return n;
  endfunction
endpackage

// File: rtl/rxq_ring.sv
module rxq_ring #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 8,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          wr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          rd_i,
  output logic [W-1:0]  rdata_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr;
  logic [CW-1:0] count_q;

  // oldest entry sits count places behind the write pointer
  assign rd_ptr  = wr_ptr_q - AW'(count_q);
  assign rdata_o = mem_q[rd_ptr];
  assign count_o = count_q;
  assign full_o  = (count_q == CW'(DEPTH));
  assign empty_o = (count_q == '0);

  always_ff @(posedge clk_i) begin
    if (wr_i && !flush_i) mem_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      count_q  <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (wr_i) wr_ptr_q <= wr_ptr_q + AW'(1);
      case ({wr_i, rd_i})
        2'b10:   count_q <= count_q + CW'(1);
        2'b01:   count_q <= count_q - CW'(1);
        default: count_q <= count_q;
      endcase
    end
  end

  // R1
  count_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CW'(DEPTH));
  // R3
  no_write_when_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && full_o) |-> rd_i);
  // R4
  no_read_when_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |-> !empty_o);
endmodule

// File: rtl/rxq_timer.sv
module rxq_timer
  import uart_rxq_pkg::*;
#(
  parameter int unsigned BCW = 16,
  localparam int unsigned WW = BCW + 6
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           restart_i,
  input  logic [7:0]     mode_i,
  input  logic [BCW-1:0] bit_cycles_i,
  output logic           expire_o
);
  logic [WW-1:0] win, cnt_q;
  logic          armed_q;

  assign win = (WW'(frame_bits(mode_i)) * WW'(bit_cycles_i)) << 2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      armed_q  <= 1'b0;
      expire_o <= 1'b0;
    end else begin
      expire_o <= 1'b0;
      if (restart_i) begin
        cnt_q   <= win;
        armed_q <= (win != '0);
      end else if (armed_q) begin
        if (cnt_q == WW'(1)) begin
          armed_q  <= 1'b0;
          cnt_q    <= '0;
          expire_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q - WW'(1);
        end
      end
    end
  end

  // R6
  expire_needs_armed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |-> ($past(armed_q) && !$past(restart_i)));
  // R6
  expire_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> !expire_o);
endmodule

// File: rtl/uart_rxq.sv
module uart_rxq
  import uart_rxq_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned BCW   = 16,
  localparam int unsigned CW   = $clog2(DEPTH) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic [3:0]        ctrl_wdata_i,
  output logic [3:0]        ctrl_o,
  input  logic [7:0]        mode_i,
  input  logic [BCW-1:0]    bit_cycles_i,
  input  logic              push_i,
  input  logic [BYTE_W-1:0] push_data_i,
  input  logic              break_i,
  input  logic              pop_i,
  output logic [BYTE_W-1:0] pop_data_o,
  output logic [CW-1:0]     count_o,
  output logic              overflow_o,
  output logic              timeout_o
);
  logic              en_q, dis_q, rx_on, flush, char_in;
  logic              wr_ok, rd_ok, ovf_d, full, empty;
  logic [BYTE_W-1:0] char_data, rdata;

  assign rx_on     = en_q & ~dis_q;
  assign flush     = ctrl_we_i & ctrl_wdata_i[0];
  assign char_in   = push_i | break_i;
  assign char_data = break_i ? '0 : push_data_i;
  assign rd_ok     = pop_i & rx_on & ~empty & ~flush;
  assign wr_ok     = char_in & rx_on & ~flush & (~full | rd_ok);
  assign ovf_d     = char_in & rx_on & ~flush & full & ~rd_ok;
  assign pop_data_o = (rx_on && !empty) ? rdata : '0;
  assign ctrl_o    = {dis_q, en_q, 2'b00};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q       <= 1'b0;
      dis_q      <= 1'b1;
      overflow_o <= 1'b0;
    end else begin
      overflow_o <= ovf_d;
      if (ctrl_we_i) begin
        en_q  <= ctrl_wdata_i[2];
        dis_q <= ctrl_wdata_i[3];
      end
    end
  end

  rxq_ring #(.DEPTH(DEPTH), .W(BYTE_W)) u_ring (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush),
    .wr_i    (wr_ok),
    .wdata_i (char_data),
    .rd_i    (rd_ok),
    .rdata_o (rdata),
    .count_o (count_o),
    .full_o  (full),
    .empty_o (empty)
  );

  rxq_timer #(.BCW(BCW)) u_timer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .restart_i    (wr_ok),
    .mode_i       (mode_i),
    .bit_cycles_i (bit_cycles_i),
    .expire_o     (timeout_o)
  );

  // R2
  gated_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_on && !flush) |=> $stable(count_o));
  // R3
  overflow_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |-> ($past(count_o) == CW'(DEPTH) && count_o == CW'(DEPTH)));
  // R5
  flush_empties_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush |=> (count_o == '0));
  // R9
  full_swap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i && rx_on && !flush && count_o == CW'(DEPTH))
      |=> (!overflow_o && count_o == CW'(DEPTH)));
endmodule

// File: tb/uart_rxq_bench.sv
`timescale 1ns/1ps
module uart_rxq_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ctrl_we_i = 1'b0;
  logic [3:0] ctrl_wdata_i = '0;
  logic [3:0] ctrl_o;
  logic [7:0] mode_i = 8'hC0;
  logic [15:0] bit_cycles_i = 16'd0;
  logic       push_i = 1'b0;
  logic [7:0] push_data_i = '0;
  logic       break_i = 1'b0;
  logic       pop_i = 1'b0;
  logic [7:0] pop_data_o;
  logic [4:0] count_o;
  logic       overflow_o, timeout_o;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #4 clk_i = ~clk_i;

  uart_rxq u_uart_rxq (.*);

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_ctrl(input logic [3:0] v);
    @(negedge clk_i); ctrl_we_i = 1'b1; ctrl_wdata_i = v;
    @(negedge clk_i); ctrl_we_i = 1'b0;
  endtask

  task automatic push(input logic [7:0] d);
    @(negedge clk_i); push_i = 1'b1; push_data_i = d;
    @(negedge clk_i); push_i = 1'b0;
  endtask

  task automatic pop(output logic [7:0] d);
    @(negedge clk_i); pop_i = 1'b1; #1 d = pop_data_o;
    @(negedge clk_i); pop_i = 1'b0;
  endtask

  // cycles to first timeout pulse after a capture edge
  task automatic wait_timeout(input int limit, output int k);
    k = 0;
    while (!timeout_o && k < limit) begin
      @(negedge clk_i); k++;
    end
  endtask

  initial begin
    logic [7:0] d;
    int k;
    repeat (3) @(negedge clk_i);
    // R10
    check("R10 count", count_o, 0);
    check("R10 ctrl", ctrl_o, 8);
    check("R10 pulses", {overflow_o, timeout_o}, 0);
    rst_ni = 1'b1;

    // R2 disabled at reset: push ignored
    push(8'h55);
    check("R2 push ignored", count_o, 0);
    wr_ctrl(4'b1100);
    push(8'h55);
    check("R2 en+dis push ignored", count_o, 0);

    wr_ctrl(4'b0100);
    check("R5 ctrl readback", ctrl_o, 4);
    // R4
    pop(d);
    check("R4 empty pop data", d, 0);
    check("R4 empty pop count", count_o, 0);

    // R1 fill then R3 overflow
    for (int i = 0; i < 16; i++) push(8'(8'h30 + i));
    check("R1 full count", count_o, 16);
    push(8'hEE);
    check("R3 overflow pulse", overflow_o, 1);
    check("R3 count held", count_o, 16);
    @(negedge clk_i);
    check("R3 pulse one cycle", overflow_o, 0);

    // R9 push+pop on full
    @(negedge clk_i); push_i = 1'b1; pop_i = 1'b1; push_data_i = 8'hA5;
    #1 d = pop_data_o;
    @(negedge clk_i); push_i = 1'b0; pop_i = 1'b0;
    check("R9 popped oldest", d, 8'h30);
    check("R9 count", count_o, 16);
    check("R9 no overflow", overflow_o, 0);

    // R2 disabled: pop ignored, data reads 0
    wr_ctrl(4'b1000);
    pop(d);
    check("R2 pop data zero", d, 0);
    check("R2 pop count held", count_o, 16);
    wr_ctrl(4'b0100);

    for (int i = 1; i < 16; i++) begin
      pop(d);
      check("R1 order", d, 8'h30 + i);
    end
    pop(d);
    check("R9 new byte last", d, 8'hA5);
    check("R1 drained", count_o, 0);

    // R1 wrap-around with offset pointers
    for (int i = 0; i < 10; i++) push(8'(i));
    for (int i = 0; i < 10; i++) pop(d);
    for (int i = 0; i < 16; i++) push(8'(8'hC0 + i));
    for (int i = 0; i < 16; i++) begin
      pop(d);
      check("R1 wrap order", d, 8'hC0 + i);
    end

    // R8 break
    @(negedge clk_i); break_i = 1'b1; push_data_i = 8'h77;
    @(negedge clk_i); break_i = 1'b0;
    check("R8 break count", count_o, 1);
    pop(d);
    check("R8 break byte", d, 0);

    // R5 flush
    for (int i = 0; i < 5; i++) push(8'(i + 1));
    wr_ctrl(4'b0101);
    check("R5 flush count", count_o, 0);
    check("R5 bit0 reads 0", ctrl_o, 4);

    // R6 R7 sweep over line formats
    for (int dc = 0; dc < 4; dc++)
      for (int pi = 0; pi < 3; pi++)
        for (int sc = 2; sc < 4; sc++) begin
          int par, fb, bc, t;
          par = (pi == 2) ? 4 : pi;
          bc  = 2 + (dc % 2);
          fb  = 1 + ((dc == 3) ? 6 : (dc == 2) ? 7 : 8) + ((par < 2) ? 1 : 0)
                  + ((sc == 3) ? 1 : 2);
          t   = 4 * fb * bc;
          mode_i = {2'(sc), 3'(par), 2'(dc), 1'b0};
          bit_cycles_i = 16'(bc);
          wr_ctrl(4'b0101);
          push(8'h11);
          wait_timeout(t + 8, k);
          check("R7 R6 timeout cycle", k, t);
          @(negedge clk_i);
          check("R6 pulse width", timeout_o, 0);
        end

    // R6 restart on each char
    mode_i = 8'hC0; bit_cycles_i = 16'd2;   // 11 bits, T = 88
    wr_ctrl(4'b0101);
    push(8'h01);
    repeat (39) @(negedge clk_i);
    push(8'h02);
    wait_timeout(200, k);
    check("R6 restart timing", k, 88);

    // R6 zero bit period disables
    bit_cycles_i = 16'd0;
    push(8'h03);
    wait_timeout(60, k);
    check("R6 zero period no timeout", timeout_o, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule